// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating analog-to-digital converter. After a start request it runs three timed phases. First it shorts the external integrator for a fixed auto-zero interval. Next it connects the analog input to the integrator for exactly 2^N clocks. Finally it switches the integrator to the negative reference and counts clocks until the external comparator reports that the integrator is back at zero. That count is the conversion result. A full-scale input therefore discharges in about 2^N clocks.

The integrator, the analog switches and the comparator are outside the block. The block drives one select line per switch and samples a comparator level. It assumes that level is already synchronous to its clock. If the comparator stays silent for too long, the conversion is cut short, the result is saturated and an overrange flag is raised.

Top module: `dsadc_seq`

## Requirements
- R1: After reset, busy, done and overrange are 0, the result is 0 and all three switch selects are open (0).
- R2: A start sampled high while idle closes the integrator-zero switch at the next clock, for exactly AZ_CYCLES clocks (16 by default).
- R3: Directly after auto-zero, the input switch is closed for exactly 2^RES_W clocks.
- R4: Directly after integration, the reference switch closes and stays closed until the conversion ends.
- R5: The result equals the number of reference-phase clocks that ended with the comparator sampled low, before the clock in which it is sampled high.
- R6: A result count of 2^RES_W does not fit in the result field. It is reported as all ones, with overrange 0.
- R7: If the comparator is still low at the end of the (2^RES_W+1)-th reference clock, the conversion ends with overrange 1 and the result all ones.
- R8: At the end of a conversion, done is high for exactly one clock and busy falls in that same clock. Result and overrange then hold their values until the next conversion ends.
- R9: A start sampled while busy has no effect: phase lengths, result and timing are unchanged.
- R10: At most one of the three switch selects is closed in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_zero_i | input | 1 | Comparator: high once the integrator has reached zero |
| sw_input_o | output | 1 | Closes the switch from analog input to integrator |
| sw_ref_o | output | 1 | Closes the switch from negative reference to integrator |
| sw_zero_o | output | 1 | Closes the integrator reset switch |
| result_o | output | RES_W | Captured discharge count |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock end-of-conversion pulse |
| ovr_o | output | 1 | Last conversion ran out of range |

## Verification
The hardest conditions to reach from the ports are the two upper edges of the discharge count: a comparator that fires on exactly the 2^RES_W-th reference clock, and one that never fires at all. The bench builds a behavioural integrator that adds an input code every integrate clock and subtracts 2^RES_W every reference clock. Each charge level therefore maps to one exact discharge count. Choosing input codes of 2^RES_W-1, 2^RES_W and 2^RES_W+2 steers the design onto the last in-range count, the saturating count and the overrange cut-off. A start pulse injected during integration checks that requests arriving mid-conversion are ignored.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ZERO  = 2'd1,
    PH_INTEG = 2'd2,
    PH_DEINT = 2'd3
  } phase_e;
endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int AZ_CYCLES = 16,
  parameter int CW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          cmp_zero_i,
  output phase_e        phase_o,
  output logic [CW-1:0] cnt_o,
  output logic          finish_o,
  output logic          ovr_evt_o
);
  localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_CYCLES - 1);
  localparam logic [CW-1:0] INT_LAST = CW'((1 << RES_W) - 1);
  localparam logic [CW-1:0] OVR_LIM  = CW'(1 << RES_W);

  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q + 1'b1;
    cnt_en    = 1'b0;
    finish_o  = 1'b0;
    ovr_evt_o = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          state_d = PH_ZERO;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      PH_ZERO: begin
        cnt_en = 1'b1;
        if (cnt_q == AZ_LAST) begin
          state_d = PH_INTEG;
          cnt_d   = '0;
        end
      end
      PH_INTEG: begin
        cnt_en = 1'b1;
        if (cnt_q == INT_LAST) begin
          state_d = PH_DEINT;
          cnt_d   = '0;
        end
      end
      PH_DEINT: begin
        if (cmp_zero_i) begin
          state_d  = PH_IDLE;
          finish_o = 1'b1;
        end else if (cnt_q == OVR_LIM) begin
          state_d   = PH_IDLE;
          finish_o  = 1'b1;
          ovr_evt_o = 1'b1;
        end else begin
          cnt_en = 1'b1;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign phase_o = state_q;
  assign cnt_o   = cnt_q;

  // A start arriving during integration must not restart the sequence.
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_INTEG && start_i) |=> (state_q != PH_ZERO));

  // The discharge counter never runs past the overrange limit.
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DEINT) |-> (cnt_q <= OVR_LIM));
endmodule

// File: rtl/dsadc_capture.sv
module dsadc_capture #(
  parameter int RES_W = 8,
  parameter int CW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish_i,
  input  logic             ovr_evt_i,
  input  logic [CW-1:0]    cnt_i,
  output logic [RES_W-1:0] result_o,
  output logic             ovr_o,
  output logic             done_o
);
  logic [RES_W-1:0] res_d;
  logic             wide;

  always_comb begin
    wide  = |cnt_i[CW-1:RES_W];
    res_d = (wide || ovr_evt_i) ? '1 : cnt_i[RES_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      ovr_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        result_o <= res_d;
        ovr_o    <= ovr_evt_i;
      end
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!finish_i && done_o) |=> ($stable(result_o) && $stable(ovr_o)));
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int RES_W     = 8,
  parameter int AZ_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_zero_i,
  output logic             sw_input_o,
  output logic             sw_ref_o,
  output logic             sw_zero_o,
  output logic [RES_W-1:0] result_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o
);
  localparam int AZ_W = $clog2(AZ_CYCLES);
  localparam int CW   = (RES_W + 1 > AZ_W) ? RES_W + 1 : AZ_W;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  phase_e        phase;
  logic [CW-1:0] cnt;
  logic          finish, ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  dsadc_ctrl #(.RES_W(RES_W), .AZ_CYCLES(AZ_CYCLES), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start_i),
    .cmp_zero_i (cmp_zero_i),
    .phase_o    (phase),
    .cnt_o      (cnt),
    .finish_o   (finish),
    .ovr_evt_o  (ovr_evt)
  );

  dsadc_capture #(.RES_W(RES_W), .CW(CW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .finish_i  (finish),
    .ovr_evt_i (ovr_evt),
    .cnt_i     (cnt),
    .result_o  (result_o),
    .ovr_o     (ovr_o),
    .done_o    (done_o)
  );

  assign sw_zero_o  = (phase == PH_ZERO);
  assign sw_input_o = (phase == PH_INTEG);
  assign sw_ref_o   = (phase == PH_DEINT);
  assign busy_o     = (phase != PH_IDLE);

  p_switch_excl_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({sw_input_o, sw_ref_o, sw_zero_o}));

  p_start_zero_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy_o && start_i) |=> sw_zero_o);

  p_ref_after_input_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sw_ref_o) |-> $past(sw_input_o));

  p_ovr_sat_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && ovr_o) |-> (&result_o));
endmodule

// File: tb/dsadc_seq_tb.sv
module dsadc_seq_tb;
  localparam int N    = 8;
  localparam int AZ   = 16;
  localparam int FULL = 1 << N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp_zero;
  logic sw_in, sw_ref, sw_zero, busy, done, ovr;
  logic [N-1:0] result;

  int vin = 0;
  longint acc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dsadc_seq #(.RES_W(N), .AZ_CYCLES(AZ)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cmp_zero_i (cmp_zero),
    .sw_input_o (sw_in),
    .sw_ref_o   (sw_ref),
    .sw_zero_o  (sw_zero),
    .result_o   (result),
    .busy_o     (busy),
    .done_o     (done),
    .ovr_o      (ovr)
  );

  // Behavioural integrator and comparator.
  always @(posedge clk) begin
    if (sw_zero)     acc <= 0;
    else if (sw_in)  acc <= acc + vin;
    else if (sw_ref) acc <= acc - FULL;
  end
  assign cmp_zero = (acc <= 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 result", result, 0);
    chk("R1 switches", {sw_in, sw_ref, sw_zero}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", busy, 0);
  endtask

  task automatic run_conv(string tag, int x, bit poke);
    int nb = 0, nz = 0, ni = 0, nr = 0, nov = 0, guard = 0;
    int exp_res, exp_ovr, exp_ref;
    logic [N-1:0] held;
    if (x > FULL) begin
      exp_res = FULL - 1; exp_ovr = 1; exp_ref = FULL + 1;
    end else begin
      exp_res = (x > FULL - 1) ? FULL - 1 : x; exp_ovr = 0; exp_ref = x + 1;
    end
    vin = x;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk({tag, " R2 zero at first clock"}, sw_zero, 1);
    while (!done && guard < 2000) begin
      if (busy) nb++;
      if (sw_zero) nz++;
      if (sw_in) ni++;
      if (sw_ref) nr++;
      if ((sw_zero + sw_in + sw_ref) > 1) nov++;
      start = (poke && nb == 100) ? 1'b1 : 1'b0;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk({tag, " R8 done seen"}, done, 1);
    chk({tag, " R8 busy low at done"}, busy, 0);
    chk({tag, " R2 zero length"}, nz, AZ);
    chk({tag, " R3 input length"}, ni, FULL);
    chk({tag, " R4 ref length"}, nr, exp_ref);
    chk({tag, " R10 overlap"}, nov, 0);
    chk({tag, " R9 busy length"}, nb, AZ + FULL + exp_ref);
    chk({tag, " R5 result"}, result, exp_res);
    chk({tag, " R7 ovr"}, ovr, exp_ovr);
    held = result;
    @(negedge clk);
    chk({tag, " R8 done one cycle"}, done, 0);
    repeat (5) @(negedge clk);
    chk({tag, " R8 result held"}, result, held);
    chk({tag, " R8 ovr held"}, ovr, exp_ovr);
  endtask

  initial begin
    t_reset();
    run_conv("mid", 100, 1'b0);
    run_conv("zero input", 0, 1'b0);
    run_conv("R5 last in range", FULL - 1, 1'b0);
    run_conv("R6 saturating", FULL, 1'b0);
    run_conv("R7 overrange", FULL + 2, 1'b0);
    run_conv("R7 clear after ovr", 5, 1'b0);
    run_conv("R9 start while busy", 42, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule